// File: doc/BRIEF.md
# Run-Length Sample Encoder

This block sits between the sample capture path of a logic analyzer and its sample memory. It compresses the capture stream into value words and count words. Each accepted sample is masked to the active width of 8, 16 or `DATA_W` bits. When compression is on, a run of identical samples leaves the block as one value word followed by one count word. The count word has a flag in the top bit of the active width, and the bits below the flag give the run length, including the sample that the value word carries. After every count word the next word is always a fresh value word, so a reader that starts at any value word can decode the rest of the stream. When compression is off, every sample passes through unchanged.

Words leave through a one-entry output register with a valid/ready handshake. The sample input stalls through `in_ready` while the output register is full, while a value word waits behind a count word, and while `flush` is high. `flush` closes the open run before capture stops. `cfg_width` and `rle_en` may change only after a flush has completed and the output has drained. `cfg_width` uses this encoding: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select `DATA_W` bits. `DATA_W` is at least 16.

The control is a three-state machine. **IDLE** means no run is open. **RUN** means a value word has been issued and its run is being counted. **VALP** means a count word has just been issued and the new sample is parked as a pending value word.
- Transitions out of IDLE: *pass* (IDLE→IDLE, compression off, the sample is issued raw) and *open* (IDLE→RUN, the value word is issued and the count is set to 1).
- Transitions within RUN: *extend* (equal sample, count +1) and *replace* (different sample while the count is 1, a new value word is issued).
- Transitions from RUN back to IDLE: *saturate* (an equal sample brings the count to its maximum, and the count word is issued) and *close* (on flush, the count word is issued if the run is 2 or longer).
- Transitions through VALP: *split* (RUN→VALP, a different sample ends a run of 2 or longer, the count word is issued and the new sample is parked) and *reopen* (VALP→RUN, the parked value word is issued).

Top module: `rle_encoder`

## Requirements
- R1: A run of N ≥ 2 equal samples with compression on produces the value word followed by a count word whose count field equals N, the value sample included.
- R2: The word after any count word is always a value word, even when the next sample equals the value of the run that just ended.
- R3: The flag is bit 7, 15 or `DATA_W`-1 for `cfg_width` 0, 1 or 2/3. The count field is the bits below the flag. All word bits above the active width are zero.
- R4: The count saturates at 127 (8-bit), 32767 (16-bit) or 2^(`DATA_W`-1)-1. The sample that brings the count to the maximum causes that count word to be issued, and the next equal sample starts a new value word.
- R5: A run of exactly one sample produces a value word only, and no count word.
- R6: With `rle_en` low, every accepted sample is issued as one word equal to the masked sample, even if its top bit is set, and no count word is produced.
- R7: While `flush` is high, `in_ready` is low. A flush issues the count word of an open run of 2 or longer, issues nothing for an open run of 1, and the next sample starts a new value word.
- R8: Sample bits above the active width are ignored, both in the issued words and in the equality comparison.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. No word is lost or duplicated, and `in_ready` is low while a value word is pending.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 2 | Active sample width: 0 = 8, 1 = 16, 2/3 = DATA_W |
| rle_en | input | 1 | Compression enable |
| flush | input | 1 | Close the open run |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted this cycle when in_valid is high |
| in_data | input | DATA_W | Sample |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Memory takes the word |
| out_data | output | DATA_W | Value or count word |

## Verification
The hardest cases to reach are the saturation boundary and the split with a pending value under backpressure. At the boundary, an equal sample brings the count to the maximum in the same cycle that the output is stalled. In the split, a different sample ends a long run while `out_ready` toggles, so the parked value word has to wait in VALP. The bench drives directed runs of exactly 127 + 3 samples in 8-bit mode and 32767 + 1 samples in 16-bit mode, and applies random `out_ready` throughout. It also mixes random runs drawn from a small set of values, which produces many splits, single-sample runs and flushes while runs are open.

// File: rtl/rle_enc_pkg.sv
package rle_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_VALP
    } rle_state_e;

    typedef enum logic [1:0] {
        TRK_HOLD,
        TRK_START,
        TRK_BUMP,
        TRK_PARK
    } trk_op_e;

endpackage

// File: rtl/rle_width_mask.sv
module rle_width_mask #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]          sel,
    input  logic [DATA_W-1:0]   raw,
    output logic [DATA_W-1:0]   masked,
    output logic [DATA_W-1:0]   keep,
    output logic [DATA_W-1:0]   flag,
    output logic [DATA_W-2:0]   cnt_max
);
    localparam int CNT_W = DATA_W - 1;

    always_comb begin
        unique case (sel)
            2'd0: begin
                keep    = DATA_W'(8'hFF);
                flag    = DATA_W'(8'h80);
                cnt_max = CNT_W'(7'h7F);
            end
            2'd1: begin
                keep    = DATA_W'(16'hFFFF);
                flag    = DATA_W'(16'h8000);
                cnt_max = CNT_W'(15'h7FFF);
            end
            default: begin
                keep    = '1;
                flag    = {1'b1, {CNT_W{1'b0}}};
                cnt_max = '1;
            end
        endcase
    end

    assign masked = raw & keep;

endmodule

// File: rtl/rle_run_track.sv
module rle_run_track
    import rle_enc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  trk_op_e             op,
    input  logic [DATA_W-1:0]   src,
    output logic [DATA_W-1:0]   run_val,
    output logic [DATA_W-2:0]   run_cnt,
    output logic [DATA_W-1:0]   pend_val
);
    localparam int CNT_W = DATA_W - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_val  <= '0;
            run_cnt  <= '0;
            pend_val <= '0;
        end else begin
            unique case (op)
                TRK_START: begin
                    run_val <= src;
                    run_cnt <= CNT_W'(1);
                end
                TRK_BUMP:  run_cnt  <= run_cnt + CNT_W'(1);
                TRK_PARK:  pend_val <= src;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/rle_out_reg.sv
module rle_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DATA_W-1:0]   load_word,
    input  logic                load_cnt,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_is_cnt,
    output logic                slot_free
);
    assign slot_free = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_is_cnt <= 1'b0;
        end else if (load) begin
            out_valid  <= 1'b1;
            out_data   <= load_word;
            out_is_cnt <= load_cnt;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/rle_encoder.sv
module rle_encoder
    import rle_enc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_width,
    input  logic                rle_en,
    input  logic                flush,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data
);
    localparam int CNT_W = DATA_W - 1;

    rle_state_e          state, state_nxt;
    trk_op_e             trk_op;
    logic [DATA_W-1:0]   trk_src;
    logic [DATA_W-1:0]   samp_m, keep, flag;
    logic [CNT_W-1:0]    cnt_max, run_cnt;
    logic [DATA_W-1:0]   run_val, pend_val;
    logic                ld, ld_cnt, slot_free, out_is_cnt, same;
    logic [DATA_W-1:0]   ld_word;

    rle_width_mask #(.DATA_W(DATA_W)) u_mask (
        .sel     (cfg_width),
        .raw     (in_data),
        .masked  (samp_m),
        .keep    (keep),
        .flag    (flag),
        .cnt_max (cnt_max)
    );

    rle_run_track #(.DATA_W(DATA_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (trk_op),
        .src      (trk_src),
        .run_val  (run_val),
        .run_cnt  (run_cnt),
        .pend_val (pend_val)
    );

    rle_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld),
        .load_word  (ld_word),
        .load_cnt   (ld_cnt),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_is_cnt (out_is_cnt),
        .slot_free  (slot_free)
    );

    assign same = (samp_m == run_val);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state and word issue
    always_comb begin
        state_nxt = state;
        trk_op    = TRK_HOLD;
        trk_src   = samp_m;
        ld        = 1'b0;
        ld_cnt    = 1'b0;
        ld_word   = samp_m;
        in_ready  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = slot_free && !flush;
                if (in_valid && in_ready) begin
                    ld = 1'b1;                        // pass or open
                    if (rle_en) begin
                        trk_op    = TRK_START;
                        state_nxt = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (slot_free) begin
                    if (flush) begin                  // close
                        if (run_cnt > CNT_W'(1)) begin
                            ld      = 1'b1;
                            ld_cnt  = 1'b1;
                            ld_word = flag | {1'b0, run_cnt};
                        end
                        state_nxt = ST_IDLE;
                    end else begin
                        in_ready = 1'b1;
                        if (in_valid) begin
                            if (same) begin
                                if (run_cnt == cnt_max - CNT_W'(1)) begin  // saturate
                                    ld        = 1'b1;
                                    ld_cnt    = 1'b1;
                                    ld_word   = flag | {1'b0, cnt_max};
                                    state_nxt = ST_IDLE;
                                end else begin                             // extend
                                    trk_op = TRK_BUMP;
                                end
                            end else if (run_cnt > CNT_W'(1)) begin        // split
                                ld        = 1'b1;
                                ld_cnt    = 1'b1;
                                ld_word   = flag | {1'b0, run_cnt};
                                trk_op    = TRK_PARK;
                                state_nxt = ST_VALP;
                            end else begin                                 // replace
                                ld     = 1'b1;
                                trk_op = TRK_START;
                            end
                        end
                    end
                end
            end
            ST_VALP: begin
                if (slot_free) begin                  // reopen
                    ld        = 1'b1;
                    ld_word   = pend_val;
                    trk_src   = pend_val;
                    trk_op    = TRK_START;
                    state_nxt = ST_RUN;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/rle_enc_chk.sv
module rle_enc_chk
    import rle_enc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                in_ready,
    input  logic                out_valid,
    input  logic                out_ready,
    input  logic [DATA_W-1:0]   out_data,
    input  logic                out_is_cnt,
    input  logic [DATA_W-1:0]   keep,
    input  logic [DATA_W-1:0]   flag,
    input  rle_state_e          state
);
    logic last_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      last_cnt <= 1'b0;
        else if (out_valid && out_ready) last_cnt <= out_is_cnt;
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data & ~keep) == '0);

    // R3
    cnt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is_cnt |-> (out_data & flag) != '0);

    // R5
    cnt_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is_cnt |-> (out_data & ~flag) >= DATA_W'(2));

    // R2
    val_after_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && last_cnt |-> !out_is_cnt);

    // R9
    pend_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_VALP |-> !in_ready);

    // R7
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

endmodule

bind rle_encoder rle_enc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_is_cnt (out_is_cnt),
    .keep       (keep),
    .flag       (flag),
    .state      (state)
);

// File: tb/rle_encoder_tb.sv
module rle_encoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        rle_en = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int          n_chk = 0;
    int          n_fail = 0;
    string       cur_req = "R1";
    logic [31:0] exp_q[$];

    bit          m_act = 0;
    logic [31:0] m_val = '0;
    longint      m_cnt = 0;
    bit          acc;
    int          stall_pct = 0;

    always #5 clk = ~clk;

    rle_encoder #(.DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .rle_en(rle_en),
        .flush(flush), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic int wbits(logic [1:0] s);
        return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] wmask(logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic longint cmax(logic [1:0] s);
        return (longint'(1) << (wbits(s) - 1)) - 1;
    endfunction

    function automatic logic [31:0] cword(logic [1:0] s, longint n);
        return (32'd1 << (wbits(s) - 1)) | 32'(n);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_push(logic [31:0] d);
        logic [31:0] m = d & wmask(cfg_width);
        if (!rle_en) begin
            exp_q.push_back(m);
        end else if (!m_act) begin
            exp_q.push_back(m); m_act = 1; m_val = m; m_cnt = 1;
        end else if (m == m_val) begin
            if (m_cnt + 1 == cmax(cfg_width)) begin
                exp_q.push_back(cword(cfg_width, m_cnt + 1)); m_act = 0;
            end else m_cnt++;
        end else begin
            if (m_cnt > 1) exp_q.push_back(cword(cfg_width, m_cnt));
            exp_q.push_back(m); m_val = m; m_cnt = 1;
        end
    endtask

    task automatic model_flush();
        if (m_act && m_cnt > 1) exp_q.push_back(cword(cfg_width, m_cnt));
        m_act = 0;
    endtask

    // one cycle: drive, observe, advance to next falling edge
    task automatic step(bit v, logic [31:0] d, bit fl, bit rdy);
        in_valid = v; in_data = d; flush = fl; out_ready = rdy;
        #1;
        acc = in_valid && in_ready;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL %s actual=%h expected=none", cur_req, out_data);
            end else chk(cur_req, out_data, exp_q.pop_front());
        end
        if (acc) model_push(d);
        @(negedge clk);
    endtask

    task automatic send(logic [31:0] d);
        do step(1'b1, d, 1'b0, ($urandom % 100) >= stall_pct); while (!acc);
    endtask

    task automatic finish_capture(string req);
        string keep_req = cur_req;
        model_flush();
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 32'h0, 1'b1, 1'b1);
            if (i == 0) chk("R7 in_ready during flush", {31'd0, acc}, 32'd0);
        end
        for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 1'b0, 1'b1);
        chk(req, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        cur_req = keep_req;
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
        @(negedge clk);

        // R1: run of 5, then a single
        cur_req = "R1"; cfg_width = 2'd0; rle_en = 1'b1;
        repeat (5) send(32'h41);
        send(32'h42);
        finish_capture("R1 drained");

        // R5: only single-sample runs, with stalls
        cur_req = "R5"; stall_pct = 40;
        for (int i = 0; i < 20; i++) send(32'(i % 3 + 1));
        finish_capture("R5 drained");

        // R4 / R2: saturation at 127 in 8-bit mode, then same value again
        cur_req = "R4 8-bit saturate"; stall_pct = 30;
        repeat (130) send(32'h07);
        finish_capture("R4 R2 drained");

        // R4: saturation at 32767 in 16-bit mode
        cur_req = "R4 16-bit saturate"; cfg_width = 2'd1; stall_pct = 0;
        repeat (32768) send(32'hBEEF);
        finish_capture("R4 16 drained");

        // R3: 32-bit words with bit 31 set
        cur_req = "R3 32-bit"; cfg_width = 2'd2; stall_pct = 25;
        repeat (3) send(32'hC000_0001);
        repeat (2) send(32'h8000_0000);
        send(32'h0000_0001);
        finish_capture("R3 drained");

        // R6: pass-through, top bit set, no counting
        cur_req = "R6 raw"; rle_en = 1'b0; cfg_width = 2'd0;
        repeat (3) send(32'hFFFF_FF80);
        cfg_width = 2'd1;
        repeat (2) send(32'h1234_8001);
        finish_capture("R6 drained");

        // R8: upper bits ignored in the comparison
        cur_req = "R8 upper ignored"; rle_en = 1'b1; cfg_width = 2'd0;
        send(32'h0000_0023); send(32'hFFFF_FF23); send(32'h1234_5623);
        finish_capture("R8 drained");

        // R7: flush with a run of 1 and with a run of 2
        cur_req = "R7 flush";
        send(32'h11);
        finish_capture("R7 single flush");
        send(32'h11); send(32'h11);
        finish_capture("R7 pair flush");
        send(32'h11);
        finish_capture("R7 restart");

        // R9 / R2: random runs under heavy backpressure
        cur_req = "R9 random"; stall_pct = 50;
        for (int blk = 0; blk < 8; blk++) begin
            logic [31:0] cur = 32'h0;
            cfg_width = 2'($urandom % 3);
            rle_en = ($urandom % 4) != 0;
            for (int i = 0; i < 80; i++) begin
                if (($urandom % 100) < 45) begin
                    case ($urandom % 4)
                        0: cur = 32'h0;
                        1: cur = 32'hFF;
                        2: cur = 32'h5A5A_A5A5;
                        default: cur = 32'h8000_0081;
                    endcase
                end
                send(cur);
            end
            finish_capture("R9 R2 random drained");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule